// File: doc/BRIEF.md
# Bitmap Pixel Command Unit

This block carries out one pixel command on a bitmap layer that packs four 2-bit pixels into each byte of a 16K-byte video memory. A command arrives as a coordinate word, with X in bits 15:8 and Y in bits 7:0, and a packed 16-bit control word. The unit can return a byte address without touching memory. That address is either the bitmap-layer address of the pixel or the address of the byte that holds the pixel in the legacy tile-graphics (graphics-2) layout. The unit can also fetch the byte that holds the pixel and test the old pixel against a reference value. It can replace the pixel and write the byte back, and it can return the resulting pixel in the low bits of the control word.

Commands enter on a valid/ready channel. `cmd_ready` is high only while the unit is idle, and a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Results leave on a valid/ready channel. Once `res_valid` rises, it and `res_data` stay unchanged until a clock edge where `res_ready` is high. No new command is taken until that edge, so the consumer can stall the unit indefinitely. The memory port is plain: a read strobe returns data on `mem_rdata` in the next cycle, and a write strobe stores `mem_wdata` at the next edge.

Top module: `pix_rmw_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `res_valid`, `mem_rd_en` and `mem_wr_en` are low and `cmd_ready` is high.
- R2: Control bit 15 set: the result is (Y>>3)*256 + (X&0xF8) + (Y&7), zero-extended. No memory access is made. Bit 15 takes priority over bit 14.
- R3: Control bit 14 set, bit 15 clear: the result is (BML_BASE + Y*(BML_WIDTH/4) + X/4) mod 16384, and no memory access is made.
- R4: The pixel with X[1:0]=k lives in byte bits (7-2k):(6-2k). A pixel write changes only those two bits of the byte at the R3 address.
- R5: Control bit 10 set: no memory write happens.
- R6: Bits 10 and 9 clear: new pixel bits 1:0 of the control word are always written.
- R7: Bit 9 set with bit 10 clear: bit 8 set writes only if the old pixel equals reference bits 5:4, and bit 8 clear writes only if they differ.
- R8: For a pixel command, the result is the control word with bits 1:0 replaced when bit 11 is set. The replacement is the pixel value after any write. When bit 11 is clear, the control word is returned unchanged.
- R9: `cmd_ready` is low while `res_valid` is high. `res_valid` and `res_data` hold steady until taken with `res_ready`.
- R10: A pixel command issues exactly one read at the R3 address and at most one write, two cycles later, at the same address. A read and a write never share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_xy | input | 16 | X in 15:8, Y in 7:0 |
| cmd_word | input | 16 | Packed control word |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 16 | Address or updated control word |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, one cycle after strobe |

## Verification
The bench builds the unit with a 256-pixel-wide layer placed at base 0x3000. With that base, high Y values push the bitmap-layer address past 16K, so the modulo wrap of R3 is exercised. The power-of-two row width selects the shift form of the row multiply. Random coordinates and control words reach every byte lane and every compare outcome. The bench also holds the result channel stalled for random spans.

// File: rtl/pix_pkg.sv
`timescale 1ns/1ps
package pix_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_CMP, ST_WRITE, ST_RESP
  } pix_state_e;

  typedef struct packed {
    logic       gm2;
    logic       bml_addr;
    logic       rd_back;
    logic       no_wr;
    logic       cmp_en;
    logic       cmp_eq;
    logic [1:0] ref_pix;
    logic [1:0] new_pix;
  } pix_cmd_t;

  function automatic pix_cmd_t decode_cmd(input logic [15:0] w);
    pix_cmd_t c;
    c.gm2      = w[15];
    c.bml_addr = w[14];
    c.rd_back  = w[11];
    c.no_wr    = w[10];
    c.cmp_en   = w[9];
    c.cmp_eq   = w[8];
    c.ref_pix  = w[5:4];
    c.new_pix  = w[1:0];
    return c;
  endfunction
endpackage

// File: rtl/pix_addr_calc.sv
`timescale 1ns/1ps
module pix_addr_calc #(
  parameter int ADDR_W    = 14,
  parameter int BML_BASE  = 0,
  parameter int BML_WIDTH = 256
) (
  input  logic [15:0]       xy,
  output logic [ADDR_W-1:0] bml_addr,
  output logic [ADDR_W-1:0] gm2_addr,
  output logic [1:0]        lane
);
  localparam int ROW_BYTES = BML_WIDTH / 4;
  localparam bit ROW_POW2  = (ROW_BYTES & (ROW_BYTES - 1)) == 0;
  localparam int ROW_SHIFT = $clog2(ROW_BYTES);

  logic [7:0]  px, py;
  logic [31:0] row_off;
  logic [31:0] sum;

  assign px = xy[15:8];
  assign py = xy[7:0];

  generate
    if (ROW_POW2) begin : g_shift
      assign row_off = 32'(py) << ROW_SHIFT;
    end else begin : g_mult
      assign row_off = 32'(py) * 32'(ROW_BYTES);
    end
  endgenerate

  assign sum      = 32'(BML_BASE) + row_off + 32'(px[7:2]);
  assign bml_addr = sum[ADDR_W-1:0];
  assign gm2_addr = ADDR_W'({py[7:3], px[7:3], py[2:0]});
  assign lane     = px[1:0];
endmodule

// File: rtl/pix_merge.sv
`timescale 1ns/1ps
module pix_merge (
  input  logic [7:0] old_byte,
  input  logic [1:0] lane,
  input  logic       no_wr,
  input  logic       cmp_en,
  input  logic       cmp_eq,
  input  logic [1:0] ref_pix,
  input  logic [1:0] new_pix,
  output logic       do_write,
  output logic [7:0] new_byte,
  output logic [1:0] after_pix
);
  logic [1:0] lane_pix [4];
  logic [1:0] old_pix;
  logic       match;

  genvar i;
  generate
    for (i = 0; i < 4; i++) begin : g_lane
      assign lane_pix[i] = old_byte[7-2*i -: 2];
      assign new_byte[7-2*i -: 2] =
        (do_write && lane == 2'(i)) ? new_pix : lane_pix[i];
    end
  endgenerate

  assign old_pix   = lane_pix[lane];
  assign match     = (old_pix == ref_pix);
  assign do_write  = !no_wr && (!cmp_en || (cmp_eq ? match : !match));
  assign after_pix = do_write ? new_pix : old_pix;
endmodule

// File: rtl/pix_rmw_unit.sv
`timescale 1ns/1ps
module pix_rmw_unit #(
  parameter int ADDR_W    = 14,
  parameter int BML_BASE  = 0,
  parameter int BML_WIDTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [15:0]       cmd_xy,
  input  logic [15:0]       cmd_word,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [15:0]       res_data,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  import pix_pkg::*;

  pix_state_e        state;
  pix_cmd_t          dec_in, dec_q;
  logic [15:0]       cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        lane_q;
  logic [15:0]       res_q;
  logic [7:0]        wbyte_q;

  logic [ADDR_W-1:0] bml_addr, gm2_addr;
  logic [1:0]        lane;
  logic              do_write;
  logic [7:0]        new_byte;
  logic [1:0]        after_pix;

  assign dec_in = decode_cmd(cmd_word);
  assign dec_q  = decode_cmd(cmd_q);

  pix_addr_calc #(
    .ADDR_W(ADDR_W), .BML_BASE(BML_BASE), .BML_WIDTH(BML_WIDTH)
  ) i_addr (
    .xy(cmd_xy), .bml_addr(bml_addr), .gm2_addr(gm2_addr), .lane(lane)
  );

  pix_merge i_merge (
    .old_byte(mem_rdata), .lane(lane_q), .no_wr(dec_q.no_wr),
    .cmp_en(dec_q.cmp_en), .cmp_eq(dec_q.cmp_eq), .ref_pix(dec_q.ref_pix),
    .new_pix(dec_q.new_pix), .do_write(do_write), .new_byte(new_byte),
    .after_pix(after_pix)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cmd_q   <= '0;
      addr_q  <= '0;
      lane_q  <= '0;
      res_q   <= '0;
      wbyte_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_valid) begin
          cmd_q  <= cmd_word;
          addr_q <= bml_addr;
          lane_q <= lane;
          if (dec_in.gm2) begin
            res_q <= 16'(gm2_addr);
            state <= ST_RESP;
          end else if (dec_in.bml_addr) begin
            res_q <= 16'(bml_addr);
            state <= ST_RESP;
          end else begin
            state <= ST_READ;
          end
        end
        ST_READ: state <= ST_CMP;
        ST_CMP: begin
          wbyte_q <= new_byte;
          res_q   <= {cmd_q[15:2], dec_q.rd_back ? after_pix : cmd_q[1:0]};
          state   <= do_write ? ST_WRITE : ST_RESP;
        end
        ST_WRITE: state <= ST_RESP;
        ST_RESP: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign res_valid = (state == ST_RESP);
  assign res_data  = res_q;
  assign mem_rd_en = (state == ST_READ);
  assign mem_wr_en = (state == ST_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = wbyte_q;
endmodule

// File: rtl/pix_rmw_unit_chk.sv
`timescale 1ns/1ps
module pix_rmw_unit_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              chk_m,
  input logic              chk_a,
  input logic              chk_w,
  input logic              res_valid,
  input logic              res_ready,
  input logic [15:0]       res_data,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr
);
  logic acc;
  logic w_flag_q;
  assign acc = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) w_flag_q <= 1'b0;
    else if (acc) w_flag_q <= chk_w && !chk_m && !chk_a;
  end

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  p_wr_follows_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($past(mem_rd_en, 2) && mem_addr == $past(mem_addr, 2)));

  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  p_busy_while_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !cmd_ready);

  p_gm2_no_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && chk_m) |=> (!mem_rd_en && res_valid));

  p_bml_no_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && chk_a) |=> (!mem_rd_en && res_valid));

  p_no_write_when_suppressed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> !w_flag_q);
endmodule

bind pix_rmw_unit pix_rmw_unit_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .chk_m(cmd_word[15]), .chk_a(cmd_word[14]), .chk_w(cmd_word[10]),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr)
);

// File: tb/test_pix_rmw_unit.sv
`timescale 1ns/1ps
module test_pix_rmw_unit;
  localparam int ADDR_W = 14;
  localparam int BASE   = 'h3000;
  localparam int WIDTH  = 256;

  logic clk = 0;
  logic rst_n = 0;
  logic cmd_valid = 0, res_ready = 0;
  logic [15:0] cmd_xy = 0, cmd_word = 0;
  logic cmd_ready, res_valid, mem_rd_en, mem_wr_en;
  logic [15:0] res_data;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [ADDR_W-1:0] last_rd_addr, last_wr_addr;
  logic [7:0] vmem [1024];
  bit done = 0;

  always #2 clk = ~clk;

  pix_rmw_unit #(.ADDR_W(ADDR_W), .BML_BASE(BASE), .BML_WIDTH(WIDTH)) i_pix_rmw_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_xy(cmd_xy), .cmd_word(cmd_word), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= vmem[mem_addr[9:0]];
      rd_cnt = rd_cnt + 1;
      last_rd_addr = mem_addr;
    end
    if (mem_wr_en) begin
      vmem[mem_addr[9:0]] = mem_wdata;
      wr_cnt = wr_cnt + 1;
      last_wr_addr = mem_addr;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] exp_bml(input logic [15:0] xy);
    int a;
    a = BASE + int'(xy[7:0]) * (WIDTH / 4) + int'(xy[15:8]) / 4;
    return 14'(a % 16384);
  endfunction

  function automatic logic [13:0] exp_gm2(input logic [15:0] xy);
    int a;
    a = (int'(xy[7:0]) / 8) * 256 + (int'(xy[15:8]) & 'hF8) + (int'(xy[7:0]) & 7);
    return 14'(a);
  endfunction

  task automatic run_cmd(input logic [15:0] xy, input logic [15:0] cw, input int stall);
    logic [13:0] a;
    logic [7:0] ob, nb;
    logic [1:0] op, np, rp, after;
    int sh;
    bit wr, pixop;
    logic [15:0] exp_res, first;
    a = exp_bml(xy);
    pixop = !cw[15] && !cw[14];
    ob = vmem[a[9:0]];
    sh = 6 - 2 * int'(xy[9:8]);
    op = 2'((ob >> sh) & 8'h3);
    rp = cw[5:4];
    np = cw[1:0];
    wr = !cw[10] && (!cw[9] || (cw[8] ? (op == rp) : (op != rp)));
    nb = wr ? ((ob & ~(8'h3 << sh)) | (8'(np) << sh)) : ob;
    after = wr ? np : op;
    if (cw[15]) exp_res = 16'(exp_gm2(xy));
    else if (cw[14]) exp_res = 16'(a);
    else exp_res = {cw[15:2], cw[11] ? after : cw[1:0]};

    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    cmd_xy = xy; cmd_word = cw; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    while (!res_valid) @(negedge clk);
    first = res_data;
    check("R9 busy while result pending", 32'(cmd_ready), 0);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check("R9 result held", {15'(0), res_valid, first}, {15'(0), 1'b1, res_data});
    end
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
    if (cw[15])       check("R2 gm2 address", 32'(first), 32'(exp_res));
    else if (cw[14])  check("R3 bml address", 32'(first), 32'(exp_res));
    else              check("R8 result word", 32'(first), 32'(exp_res));
    if (!pixop) begin
      check("R2 R3 no memory access", rd_cnt + wr_cnt, 0);
    end else begin
      check("R10 one read", rd_cnt, 1);
      check("R10 read address", 32'(last_rd_addr), 32'(a));
      if (cw[10]) check("R5 write suppressed", wr_cnt, 0);
      else if (cw[9]) check("R7 conditional write count", wr_cnt, wr ? 1 : 0);
      else check("R6 unconditional write", wr_cnt, 1);
      if (wr) check("R10 write address", 32'(last_wr_addr), 32'(a));
      check("R4 byte after op", 32'(vmem[a[9:0]]), 32'(nb));
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) vmem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    check("R1 cmd_ready in reset", 32'(cmd_ready), 1);
    check("R1 res_valid in reset", 32'(res_valid), 0);
    check("R1 no strobes in reset", 32'(mem_rd_en | mem_wr_en), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle after reset", {30'(0), cmd_ready, res_valid}, 32'h2);

    // R2 priority over A, corners
    run_cmd(16'hFFFF, 16'hC000, 0);
    run_cmd(16'h0000, 16'h8000, 1);
    run_cmd(16'h3D2B, 16'h8000, 0);
    // R3 wrap past 16K
    run_cmd(16'hFFFF, 16'h4000, 2);
    run_cmd(16'h0500, 16'h4000, 0);
    // R4 every lane, unconditional write with read back (R6, R8)
    for (int k = 0; k < 4; k++) run_cmd({6'd5, 2'(k), 8'd9}, 16'h0800 | 16'(k ^ 1), 0);
    // R7 equal / not-equal matches and misses
    for (int k = 0; k < 4; k++) begin
      run_cmd(16'h2003, 16'h0B00 | 16'(k << 4) | 16'h2, 0);
      run_cmd(16'h2003, 16'h0A00 | 16'(k << 4) | 16'h1, 0);
    end
    // R5 read only
    run_cmd(16'h1107, 16'h0C03, 1);

    process_seed();
    for (int n = 0; n < 300; n++) begin
      logic [15:0] xy, cw;
      int cls;
      xy = 16'($urandom);
      cw = 16'($urandom);
      cls = int'($urandom % 8);
      cw[15] = (cls == 0);
      cw[14] = (cls == 1);
      run_cmd(xy, cw, int'($urandom % 4));
    end
    finish_run();
  end

  task automatic process_seed();
    void'($urandom(32'h5EED1234));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end
endmodule